// File: doc/BRIEF.md
# Comma-Aligning 20-bit Deserializer

This block takes a retimed serial stream, one bit per bit-clock cycle, and packs it into 20-bit words that each hold two 10-bit characters. The first bit received lands in word bit 0. Each finished word is presented together with a one-cycle valid strobe. The strobe repeats every 20 cycles while the word boundary stays where it is.

While alignment is enabled, every incoming bit is tested as the last bit of the 7-bit comma pattern. A comma that would not occupy word bits 0 to 6 moves the word boundary, so that the comma is emitted in bits 0 to 6 of the next word. This covers a comma in the second character and a comma that spans both characters. The word that was in progress is dropped, and one word period runs irregular. A comma flag marks the word that carries an aligned comma. A link-down flag marks a word that is all zeros or all ones while the line input is selected. A select input swaps the line input for a loopback bit.

Top module: `des_comma_align`

## Requirements
- R1: With no comma present, bits are packed first-received into word bit 0. `word_vld_o` pulses for one cycle every 20 bit cycles, and `word_o` carries the last 20 bits.
- R2: When `lpbk_sel_i` is 1 the deserialized stream is taken from `lpbk_bit_i`, and `ser_i` is ignored. When it is 0, `lpbk_bit_i` is ignored.
- R3: A comma is the 7-bit arrival sequence 0,0,1,1,1,1,1, which gives `word_o[6:0]` = 7'b1111100. When it completes at word position 6, the boundary is kept and the word carrying it has `comma_o` = 1.
- R4: With `align_en_i` = 1, a comma completing at any other position shifts the boundary. The next emitted word has the comma in bits 6:0, with the 13 bits that follow it in bits 19:7, and `comma_o` = 1. This holds for a comma in the second character and for one that spans both characters.
- R5: With `align_en_i` = 0 the boundary never moves and `comma_o` stays 0, even when a word carries an aligned comma.
- R6: `comma_o` is high only for the word that carries the comma, and it drops on the next word if that word has none.
- R7: `link_down_o` is 1 for a word that is all zeros or all ones while `lpbk_sel_i` = 0. It is 0 for any other word, and for any word while loopback is selected.
- R8: `word_o`, `comma_o` and `link_down_o` change only on a strobe. A realignment produces exactly one strobe for the comma word, after a gap equal to the number of bits received since the previous strobe. There are never two strobes back to back.
- R9: While reset is active, all outputs are 0 and the word position restarts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_i | input | 1 | Line serial bit |
| lpbk_sel_i | input | 1 | 1 selects the loopback bit as input |
| lpbk_bit_i | input | 1 | Loopback serial bit |
| align_en_i | input | 1 | Enables comma realignment and the comma flag |
| word_o | output | 20 | Deserialized word, bit 0 received first |
| word_vld_o | output | 1 | One-cycle strobe per new word |
| comma_o | output | 1 | Word carries an aligned comma |
| link_down_o | output | 1 | Word is all zeros or all ones on the line input |

## Verification
The assertions assume that `align_en_i` and `lpbk_sel_i` are stable at the edge that completes a word. The comma and link-down checks compare the flags against those inputs as sampled one edge earlier. The strobe-gap bounds assume at most one realignment between strobes, which is what any single comma can cause. The stimulus changes inputs only at the falling edge and holds both selects constant across whole words. It uses data words with no run of five ones, so that no stray comma forms across word boundaries.

// File: rtl/des_pkg.sv
package des_pkg;
  localparam int unsigned WORD_W_DEF  = 20;
  localparam int unsigned COMMA_W_DEF = 7;
  // bit 0 is the earliest arrival: 0,0,1,1,1,1,1
  localparam logic [6:0]  COMMA_PAT_DEF = 7'b111_1100;
endpackage

// File: rtl/des_shift_win.sv
module des_shift_win #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  output logic [W-1:0] win_o
);
  logic [W-2:0] hist_q;

  // newest bit at top, oldest at bit 0
  assign win_o = {bit_i, hist_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= win_o[W-1:1];
  end
endmodule

// File: rtl/des_comma_scan.sv
module des_comma_scan #(
  parameter int unsigned    CW  = 7,
  parameter logic [CW-1:0]  PAT = '0
) (
  input  logic [CW-1:0] tail_i,
  input  logic [CW-1:0] head_i,
  output logic          tail_hit_o,
  output logic          head_hit_o
);
  // tail: comma just completed; head: comma sits in word bits 0..CW-1
  assign tail_hit_o = (tail_i == PAT);
  assign head_hit_o = (head_i == PAT);
endmodule

// File: rtl/des_phase_ctl.sv
module des_phase_ctl #(
  parameter int unsigned W  = 20,
  parameter int unsigned CW = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic align_en_i,
  output logic word_end_o
);
  localparam int unsigned PH_W = $clog2(W);
  localparam logic [PH_W-1:0] POS_COMMA = PH_W'(CW - 1);
  localparam logic [PH_W-1:0] POS_LAST  = PH_W'(W - 1);

  logic [PH_W-1:0] cnt_q;
  logic [PH_W-1:0] pos;

  // a comma forces the current bit to be the last comma bit of a word
  always_comb begin
    pos = cnt_q;
    if (hit_i && align_en_i) pos = POS_COMMA;
  end

  assign word_end_o = (pos == POS_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (word_end_o) cnt_q <= '0;
    else                 cnt_q <= pos + 1'b1;
  end
endmodule

// File: rtl/des_out_reg.sv
module des_out_reg #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         word_end_i,
  input  logic [W-1:0] win_i,
  input  logic         head_hit_i,
  input  logic         align_en_i,
  input  logic         lpbk_sel_i,
  output logic [W-1:0] word_o,
  output logic         word_vld_o,
  output logic         comma_o,
  output logic         link_down_o
);
  logic uniform;
  assign uniform = (&win_i) | ~(|win_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o      <= '0;
      word_vld_o  <= 1'b0;
      comma_o     <= 1'b0;
      link_down_o <= 1'b0;
    end else begin
      word_vld_o <= word_end_i;
      if (word_end_i) begin
        word_o      <= win_i;
        comma_o     <= head_hit_i & align_en_i;
        link_down_o <= uniform & ~lpbk_sel_i;
      end
    end
  end
endmodule

// File: rtl/des_comma_align.sv
module des_comma_align
  import des_pkg::*;
#(
  parameter int unsigned           WORD_W    = WORD_W_DEF,
  parameter int unsigned           COMMA_W   = COMMA_W_DEF,
  parameter logic [COMMA_W-1:0]    COMMA_PAT = COMMA_PAT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              lpbk_sel_i,
  input  logic              lpbk_bit_i,
  input  logic              align_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              comma_o,
  output logic              link_down_o
);
  logic              bit_in;
  logic [WORD_W-1:0] win;
  logic              tail_hit, head_hit, word_end;

  assign bit_in = lpbk_sel_i ? lpbk_bit_i : ser_i;

  des_shift_win #(.W(WORD_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (bit_in),
    .win_o  (win)
  );

  des_comma_scan #(.CW(COMMA_W), .PAT(COMMA_PAT)) u_scan (
    .tail_i     (win[WORD_W-1 -: COMMA_W]),
    .head_i     (win[COMMA_W-1:0]),
    .tail_hit_o (tail_hit),
    .head_hit_o (head_hit)
  );

  des_phase_ctl #(.W(WORD_W), .CW(COMMA_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (tail_hit),
    .align_en_i (align_en_i),
    .word_end_o (word_end)
  );

  des_out_reg #(.W(WORD_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_end_i  (word_end),
    .win_i       (win),
    .head_hit_i  (head_hit),
    .align_en_i  (align_en_i),
    .lpbk_sel_i  (lpbk_sel_i),
    .word_o      (word_o),
    .word_vld_o  (word_vld_o),
    .comma_o     (comma_o),
    .link_down_o (link_down_o)
  );
endmodule

// File: rtl/des_comma_align_chk.sv
module des_comma_align_chk #(
  parameter int unsigned        WORD_W    = 20,
  parameter int unsigned        COMMA_W   = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lpbk_sel_i,
  input logic              align_en_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o,
  input logic              comma_o,
  input logic              link_down_o
);
  logic [7:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= '0;
    else if (word_vld_o)  gap_q <= '0;
    else if (gap_q != '1) gap_q <= gap_q + 1'b1;
  end

  p_comma_pat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comma_o |-> (word_o[COMMA_W-1:0] == COMMA_PAT));

  p_comma_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && !$past(align_en_i)) |-> !comma_o);

  p_link_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> (link_down_o == (!$past(lpbk_sel_i) && ((&word_o) || !(|word_o)))));

  p_hold_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> ($stable(word_o) && $stable(comma_o) && $stable(link_down_o)));

  p_vld_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  p_gap_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < 8'(2 * WORD_W));

  p_gap_min_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> (gap_q >= 8'(WORD_W - COMMA_W)));
endmodule

bind des_comma_align des_comma_align_chk #(
  .WORD_W(WORD_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lpbk_sel_i  (lpbk_sel_i),
  .align_en_i  (align_en_i),
  .word_o      (word_o),
  .word_vld_o  (word_vld_o),
  .comma_o     (comma_o),
  .link_down_o (link_down_o)
);

// File: tb/des_comma_align_tb.sv
module des_comma_align_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0]  COMMA = 7'b111_1100;
  localparam logic [19:0] WA = 20'h6B5A9;
  localparam logic [19:0] WB = 20'h2D4B3;
  localparam logic [19:0] WC = 20'h6B57C;
  localparam logic [9:0]  F10 = 10'b0100101101;
  localparam logic [6:0]  F7  = 7'b0101101;
  localparam logic [12:0] PAY = 13'h0A56;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser = 1'b0, lsel = 1'b0, lbit = 1'b0, aen = 1'b1;
  logic [19:0] word_o;
  logic word_vld_o, comma_o, link_down_o;

  int checks = 0, fails = 0, cyc = 0, n = 0;
  logic [19:0] log_w [64];
  logic        log_c [64];
  logic        log_l [64];
  int          log_t [64];
  logic [19:0] prev_w = '0;
  logic        prev_c = 1'b0, prev_l = 1'b0, hold_bad = 1'b0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  des_comma_align u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .lpbk_sel_i(lsel),
    .lpbk_bit_i(lbit), .align_en_i(aen), .word_o(word_o),
    .word_vld_o(word_vld_o), .comma_o(comma_o), .link_down_o(link_down_o)
  );

  always @(posedge clk) begin
    #2;
    cyc++;
    if (word_vld_o && n < 64) begin
      log_w[n] = word_o; log_c[n] = comma_o; log_l[n] = link_down_o; log_t[n] = cyc;
      n++;
    end
    if (rst_n && !word_vld_o &&
        (word_o !== prev_w || comma_o !== prev_c || link_down_o !== prev_l))
      hold_bad = 1'b1;
    prev_w = word_o; prev_c = comma_o; prev_l = link_down_o;
  end

  task automatic chk(input logic ok, input string msg, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // caller stands at a falling edge; returns at the next falling edge
  task automatic send_bit(input logic b);
    if (lsel) begin lbit = b; ser = ~b; end
    else      begin ser = b;  lbit = ~b; end
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [19:0] v, input int cnt);
    for (int i = 0; i < cnt; i++) send_bit(v[i]);
  endtask

  task automatic expect_word(input int idx, input logic [19:0] w, input logic c,
                             input logic l, input int gap, input string tag);
    chk(n > idx, {tag, " strobe present"}, n, idx + 1);
    if (n > idx) begin
      chk(log_w[idx] == w, {tag, " word"}, log_w[idx], w);
      chk(log_c[idx] == c, {tag, " comma flag"}, log_c[idx], c);
      chk(log_l[idx] == l, {tag, " link down"}, log_l[idx], l);
      if (gap > 0 && idx > 0)
        chk(log_t[idx] - log_t[idx-1] == gap, {tag, " strobe gap"},
            log_t[idx] - log_t[idx-1], gap);
    end
  endtask

  task automatic t_reset_r9;
    @(negedge clk);
    chk(word_o == '0, "R9 reset word", word_o, 0);
    chk(!word_vld_o && !comma_o && !link_down_o, "R9 reset flags",
        {word_vld_o, comma_o, link_down_o}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic_r1;
    int n0 = n;
    send_bits(WA, 20);
    send_bits(WB, 20);
    chk(n == n0 + 2, "R1 strobe count", n - n0, 2);
    expect_word(n0, WA, 1'b0, 1'b0, 0, "R1 first");
    expect_word(n0 + 1, WB, 1'b0, 1'b0, 20, "R1 second");
  endtask

  task automatic t_loopback_r2;
    int n0 = n;
    lsel = 1'b1;
    send_bits(WB, 20);
    send_bits(20'h0, 20);
    expect_word(n0, WB, 1'b0, 1'b0, 20, "R2 loopback data");
    expect_word(n0 + 1, 20'h0, 1'b0, 1'b0, 20, "R7 zeros in loopback no link down");
    lsel = 1'b0;
  endtask

  task automatic t_link_r7;
    int n0 = n;
    aen = 1'b0;
    send_bits(20'hFFFFF, 20);
    send_bits(20'h00000, 20);
    send_bits(WA, 20);
    expect_word(n0, 20'hFFFFF, 1'b0, 1'b1, 20, "R7 all ones");
    expect_word(n0 + 1, 20'h00000, 1'b0, 1'b1, 20, "R7 all zeros");
    expect_word(n0 + 2, WA, 1'b0, 1'b0, 20, "R7 mixed word");
    aen = 1'b1;
  endtask

  task automatic t_aligned_r3;
    int n0 = n;
    send_bits(WC, 20);
    send_bits(WA, 20);
    expect_word(n0, WC, 1'b1, 1'b0, 20, "R3 aligned comma");
    expect_word(n0 + 1, WA, 1'b0, 1'b0, 20, "R6 flag drops next word");
  endtask

  task automatic t_misaligned_r4(input int pre, input string tag);
    int n0 = n;
    if (pre == 10) send_bits({10'h0, F10}, 10);
    else           send_bits({13'h0, F7}, 7);
    send_bits({13'h0, COMMA}, 7);
    send_bits({7'h0, PAY}, 13);
    chk(n == n0 + 1, {tag, " single strobe R8"}, n - n0, 1);
    expect_word(n0, {PAY, COMMA}, 1'b1, 1'b0, pre + 20, tag);
    send_bits(WA, 20);
    expect_word(n0 + 1, WA, 1'b0, 1'b0, 20, {tag, " following word R4"});
  endtask

  task automatic t_frozen_r5;
    int n0 = n;
    aen = 1'b0;
    send_bits({10'h0, F10}, 10);
    send_bits({13'h0, COMMA}, 7);
    send_bits(20'h2, 3);
    send_bits(WC, 20);
    aen = 1'b1;
    send_bits(WA, 20);
    expect_word(n0, {3'b010, COMMA, F10}, 1'b0, 1'b0, 20, "R5 boundary kept");
    expect_word(n0 + 1, WC, 1'b0, 1'b0, 20, "R5 aligned comma flag gated");
    expect_word(n0 + 2, WA, 1'b0, 1'b0, 20, "R5 phase unchanged");
  endtask

  initial begin
    t_reset_r9();
    t_basic_r1();
    t_loopback_r2();
    t_link_r7();
    t_aligned_r3();
    t_misaligned_r4(10, "R4 comma in second character");
    t_misaligned_r4(7, "R4 comma spanning characters");
    t_frozen_r5();
    chk(!hold_bad, "R8 outputs held between strobes", hold_bad, 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule